// File: doc/BRIEF.md
# Floppy Track Format Stream Generator

This block produces the byte-symbol stream that lays down a complete floppy track, in either single density (FM) or double density (MFM). A `start` pulse, given when the index pulse is seen, latches the track configuration. The block then emits the index preamble: the leading gap, the sync zeros, the index mark and the post-index gap. After that it builds one sector after another. For each sector it asks the host for four ID bytes (cylinder, head, record, size code) over a request/valid port. It then writes the ID field with its CRC, gap 2, a data field filled with one filler byte, the data CRC and gap 3.

Every output symbol is an 8-bit data byte plus a flag that tells the write channel to leave out the clock bits for that byte. This flag is how sync marks are recorded. The drive side takes a symbol on any cycle where `sym_take` is high while `sym_valid` is high. The block finishes with `done` when the sector count is used up. If the host fails to supply the first ID byte in time, it stops with `timeout`.

Top module: `fmt_track_gen`

## Requirements
- R1: The gap byte is 0x4E when `cfg_mfm`=1 and 0xFF when `cfg_mfm`=0. The stream opens with 40 gap bytes in FM and 80 in MFM.
- R2: The opening gap is followed by sync zeros (byte 0x00): 6 in FM, 12 in MFM. The same sync counts are used before every ID and data field.
- R3: The index mark is a single 0xFC with `sym_mark`=1 in FM. In MFM it is three 0xC2 bytes with `sym_mark`=1 followed by 0xFC with `sym_mark`=0.
- R4: The post-index gap is 26 gap bytes in FM and 50 in MFM.
- R5: `host_req` is high only while the block waits for a sector's ID bytes, and it drops once four bytes have been taken. A byte is taken at a rising edge where `host_req` and `host_valid` are both high. A sector's ID field starts only after all four of its bytes have been taken. With `cfg_sectors`=0, `host_req` never rises.
- R6: The ID field is made of the sync zeros, then three 0xA1 with `sym_mark`=1 (MFM only), then 0xFE (`sym_mark`=1 in FM, 0 in MFM), then the four host bytes in the order they arrived.
- R7: Each field ends with two CRC bytes, high byte first. The CRC is CRC-16 with polynomial 0x1021, preset to 0xFFFF and processed MSB first. It covers the 0xA1 bytes (MFM), the mark and the field bytes. It does not cover the sync zeros.
- R8: Gap 2 is 11 gap bytes in FM and 22 in MFM. It is followed by sync zeros, then three marked 0xA1 bytes (MFM only), then the data mark 0xFB (`sym_mark`=1 in FM, 0 in MFM).
- R9: The data field repeats `cfg_filler` `cfg_reclen` times. After the data CRC come `cfg_gap3` gap bytes. Both `cfg_reclen` and `cfg_gap3` must be at least 1.
- R10: Exactly `cfg_sectors` sectors are written. After the last symbol of the last gap 3 (or of the post-index gap when `cfg_sectors`=0) has been taken, `done` goes high and stays high until the next `start`.
- R11: If no ID byte has arrived for the first sector `TMO_CYCLES` cycles after `host_req` first rises, `timeout` rises on the next edge. At the same point `host_req` drops, and `done` stays low.
- R12: After reset, `sym_valid`, `host_req`, `done` and `timeout` are all low. `start` is accepted only when the block is idle, done or timed out and no symbol is pending.
- R13: While `sym_valid` is high and `sym_take` is low, `sym_valid`, `sym_data` and `sym_mark` hold their values. With `sym_take` held high, one symbol is delivered per cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a track; sampled when idle |
| cfg_mfm | input | 1 | 1 = MFM, 0 = FM |
| cfg_filler | input | 8 | Data field filler byte |
| cfg_gap3 | input | GAP_W | Gap 3 length in bytes (at least 1) |
| cfg_reclen | input | REC_W | Data bytes per sector (at least 1) |
| cfg_sectors | input | SEC_W | Number of sectors on the track |
| host_req | output | 1 | Waiting for an ID byte |
| host_valid | input | 1 | Host presents an ID byte |
| host_data | input | 8 | ID byte from the host |
| sym_valid | output | 1 | Output symbol present |
| sym_data | output | 8 | Output symbol byte |
| sym_mark | output | 1 | Missing-clock flag for the symbol |
| sym_take | input | 1 | Write channel consumes the symbol |
| done | output | 1 | Track complete |
| timeout | output | 1 | First ID bytes did not arrive in time |

## Verification
A symbol shows up on `sym_*` one edge after it is produced. When `sym_take` is high on an edge, the next symbol replaces the current one on that same edge. The bench therefore picks `sym_take` on the falling edge and scores the visible symbol then, knowing that it will be consumed on the following rising edge. A host byte counts as taken on the rising edge that follows the falling edge where the bench raised `host_valid` against a high `host_req`. The timeout is checked exactly: `timeout` must still be low `TMO_CYCLES` falling edges after `host_req` was first seen, and must be high one falling edge later.

// File: rtl/fmt_pkg.sv
package fmt_pkg;

  typedef enum logic [4:0] {
    SG_IDLE, SG_IGAP, SG_ISYNC, SG_IPRE, SG_IMARK, SG_PGAP, SG_WAIT,
    SG_HSYNC, SG_HPRE, SG_HMARK, SG_HFLD, SG_HCRC, SG_GAP2,
    SG_DSYNC, SG_DPRE, SG_DMARK, SG_FILL, SG_DCRC, SG_GAP3,
    SG_DONE, SG_TMO
  } seg_t;

  localparam logic [7:0] GAP_MFM   = 8'h4E;
  localparam logic [7:0] GAP_FM    = 8'hFF;
  localparam logic [7:0] PRE_INDEX = 8'hC2;
  localparam logic [7:0] PRE_FIELD = 8'hA1;
  localparam logic [7:0] MK_INDEX  = 8'hFC;
  localparam logic [7:0] MK_HEADER = 8'hFE;
  localparam logic [7:0] MK_DATA   = 8'hFB;

  localparam int LEN_IGAP_FM  = 40;
  localparam int LEN_IGAP_MFM = 80;
  localparam int LEN_SYNC_FM  = 6;
  localparam int LEN_SYNC_MFM = 12;
  localparam int LEN_PGAP_FM  = 26;
  localparam int LEN_PGAP_MFM = 50;
  localparam int LEN_GAP2_FM  = 11;
  localparam int LEN_GAP2_MFM = 22;
  localparam int LEN_PRE      = 3;
  localparam int LEN_ID       = 4;
  localparam int LEN_CRC      = 2;

  localparam logic [15:0] CRC_POLY = 16'h1021;
  localparam logic [15:0] CRC_INIT = 16'hFFFF;

  function automatic logic [15:0] crc_byte(input logic [15:0] c, input logic [7:0] d);
    logic [15:0] r;
    logic        fb;
    r = c;
    for (int i = 7; i >= 0; i--) begin
      fb = r[15] ^ d[i];
      r  = {r[14:0], 1'b0} ^ (fb ? CRC_POLY : 16'h0000);
    end
    return r;
  endfunction

endpackage

// File: rtl/fmt_crc.sv
module fmt_crc
  import fmt_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        seed,
  input  logic        step,
  input  logic [7:0]  din,
  output logic [15:0] crc
);
  always_ff @(posedge clk) begin
    if (rst)       crc <= CRC_INIT;
    else if (seed) crc <= crc_byte(CRC_INIT, din);
    else if (step) crc <= crc_byte(crc, din);
  end
endmodule

// File: rtl/fmt_id_port.sv
module fmt_id_port #(
  parameter int TMO_CYCLES = 20000
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        host_req,
  input  logic        host_valid,
  input  logic [7:0]  host_data,
  input  logic        flush,
  input  logic        arm,
  output logic        id_full,
  output logic        id_empty,
  output logic [31:0] id_flat,
  output logic        expired
);
  localparam int TMO_W = $clog2(TMO_CYCLES + 1);

  logic [2:0]       cnt_q;
  logic [3:0][7:0]  id_q;
  logic [TMO_W-1:0] tmr_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      id_q  <= '0;
    end else if (flush) begin
      cnt_q <= '0;
    end else if (host_req && host_valid && !cnt_q[2]) begin
      id_q[cnt_q[1:0]] <= host_data;
      cnt_q            <= cnt_q + 3'd1;
    end
  end

  assign id_full  = cnt_q[2];
  assign id_empty = (cnt_q == 3'd0);
  assign id_flat  = id_q;

  always_ff @(posedge clk) begin
    if (rst || !arm)  tmr_q <= '0;
    else if (!expired) tmr_q <= tmr_q + 1'b1;
  end

  assign expired = (tmr_q == TMO_W'(TMO_CYCLES));
endmodule

// File: rtl/fmt_seq.sv
module fmt_seq
  import fmt_pkg::*;
#(
  parameter int REC_W = 14,
  parameter int GAP_W = 8,
  parameter int SEC_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             cfg_mfm,
  input  logic [7:0]       cfg_filler,
  input  logic [GAP_W-1:0] cfg_gap3,
  input  logic [REC_W-1:0] cfg_reclen,
  input  logic [SEC_W-1:0] cfg_sectors,
  input  logic             id_full,
  input  logic             id_empty,
  input  logic [31:0]      id_flat,
  input  logic             expired,
  input  logic [15:0]      crc,
  input  logic             sym_take,
  output logic             flush,
  output logic             arm,
  output logic             host_req,
  output logic             crc_seed,
  output logic             crc_step,
  output logic [7:0]       crc_din,
  output logic             sym_valid,
  output logic [7:0]       sym_data,
  output logic             sym_mark,
  output logic             done,
  output logic             timeout
);
  localparam int CNT_A = (REC_W > GAP_W) ? REC_W : GAP_W;
  localparam int CNT_W = (CNT_A > 7) ? CNT_A : 7;

  seg_t             seg_q, nxt_seg;
  logic [CNT_W-1:0] cnt_q, seg_len;
  logic             mfm_q, first_q;
  logic [7:0]       fill_q;
  logic [GAP_W-1:0] gap3_q;
  logic [REC_W-1:0] rec_q;
  logic [SEC_W-1:0] left_q;
  logic             sv_q, sm_q;
  logic [7:0]       sd_q;

  logic       produce, load, last, idle_like;
  logic [7:0] cur_byte, gap_b;
  logic       cur_mark;

  always_comb begin
    case (seg_q)
      SG_IGAP:                      seg_len = mfm_q ? CNT_W'(LEN_IGAP_MFM) : CNT_W'(LEN_IGAP_FM);
      SG_ISYNC, SG_HSYNC, SG_DSYNC: seg_len = mfm_q ? CNT_W'(LEN_SYNC_MFM) : CNT_W'(LEN_SYNC_FM);
      SG_IPRE, SG_HPRE, SG_DPRE:    seg_len = CNT_W'(LEN_PRE);
      SG_PGAP:                      seg_len = mfm_q ? CNT_W'(LEN_PGAP_MFM) : CNT_W'(LEN_PGAP_FM);
      SG_HFLD:                      seg_len = CNT_W'(LEN_ID);
      SG_HCRC, SG_DCRC:             seg_len = CNT_W'(LEN_CRC);
      SG_GAP2:                      seg_len = mfm_q ? CNT_W'(LEN_GAP2_MFM) : CNT_W'(LEN_GAP2_FM);
      SG_FILL:                      seg_len = CNT_W'(rec_q);
      SG_GAP3:                      seg_len = CNT_W'(gap3_q);
      default:                      seg_len = CNT_W'(1);
    endcase
  end

  always_comb begin
    gap_b    = mfm_q ? GAP_MFM : GAP_FM;
    cur_byte = 8'h00;
    cur_mark = 1'b0;
    case (seg_q)
      SG_IGAP, SG_PGAP, SG_GAP2, SG_GAP3: cur_byte = gap_b;
      SG_IPRE:          begin cur_byte = PRE_INDEX; cur_mark = 1'b1;   end
      SG_HPRE, SG_DPRE: begin cur_byte = PRE_FIELD; cur_mark = 1'b1;   end
      SG_IMARK:         begin cur_byte = MK_INDEX;  cur_mark = !mfm_q; end
      SG_HMARK:         begin cur_byte = MK_HEADER; cur_mark = !mfm_q; end
      SG_DMARK:         begin cur_byte = MK_DATA;   cur_mark = !mfm_q; end
      SG_HFLD:          cur_byte = id_flat[{cnt_q[1:0], 3'b000} +: 8];
      SG_HCRC, SG_DCRC: cur_byte = cnt_q[0] ? crc[7:0] : crc[15:8];
      SG_FILL:          cur_byte = fill_q;
      default:          cur_byte = 8'h00;
    endcase
  end

  always_comb begin
    case (seg_q)
      SG_IGAP:  nxt_seg = SG_ISYNC;
      SG_ISYNC: nxt_seg = mfm_q ? SG_IPRE : SG_IMARK;
      SG_IPRE:  nxt_seg = SG_IMARK;
      SG_IMARK: nxt_seg = SG_PGAP;
      SG_PGAP:  nxt_seg = (left_q == '0) ? SG_DONE : SG_WAIT;
      SG_HSYNC: nxt_seg = mfm_q ? SG_HPRE : SG_HMARK;
      SG_HPRE:  nxt_seg = SG_HMARK;
      SG_HMARK: nxt_seg = SG_HFLD;
      SG_HFLD:  nxt_seg = SG_HCRC;
      SG_HCRC:  nxt_seg = SG_GAP2;
      SG_GAP2:  nxt_seg = SG_DSYNC;
      SG_DSYNC: nxt_seg = mfm_q ? SG_DPRE : SG_DMARK;
      SG_DPRE:  nxt_seg = SG_DMARK;
      SG_DMARK: nxt_seg = SG_FILL;
      SG_FILL:  nxt_seg = SG_DCRC;
      SG_DCRC:  nxt_seg = SG_GAP3;
      SG_GAP3:  nxt_seg = (left_q == SEC_W'(1)) ? SG_DONE : SG_WAIT;
      default:  nxt_seg = SG_IDLE;
    endcase
  end

  assign idle_like = (seg_q == SG_IDLE) || (seg_q == SG_DONE) || (seg_q == SG_TMO);
  assign produce   = !idle_like && (seg_q != SG_WAIT);
  assign load      = produce && (!sv_q || sym_take);
  assign last      = (cnt_q == seg_len - CNT_W'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      seg_q   <= SG_IDLE;
      cnt_q   <= '0;
      mfm_q   <= 1'b0;
      first_q <= 1'b0;
      fill_q  <= '0;
      gap3_q  <= '0;
      rec_q   <= '0;
      left_q  <= '0;
      sv_q    <= 1'b0;
      sd_q    <= '0;
      sm_q    <= 1'b0;
    end else begin
      if (load) begin
        sv_q <= 1'b1;
        sd_q <= cur_byte;
        sm_q <= cur_mark;
      end else if (sym_take) begin
        sv_q <= 1'b0;
      end

      if (idle_like) begin
        if (start && !sv_q) begin
          seg_q   <= SG_IGAP;
          cnt_q   <= '0;
          first_q <= 1'b1;
          mfm_q   <= cfg_mfm;
          fill_q  <= cfg_filler;
          gap3_q  <= cfg_gap3;
          rec_q   <= cfg_reclen;
          left_q  <= cfg_sectors;
        end
      end else if (seg_q == SG_WAIT) begin
        if (id_full) begin
          seg_q   <= SG_HSYNC;
          cnt_q   <= '0;
          first_q <= 1'b0;
        end else if (expired) begin
          seg_q <= SG_TMO;
        end
      end else if (load) begin
        if (last) begin
          seg_q <= nxt_seg;
          cnt_q <= '0;
          if (seg_q == SG_GAP3) left_q <= left_q - SEC_W'(1);
        end else begin
          cnt_q <= cnt_q + CNT_W'(1);
        end
      end
    end
  end

  assign flush    = (seg_q == SG_WAIT) && id_full;
  assign arm      = (seg_q == SG_WAIT) && first_q && id_empty;
  assign host_req = (seg_q == SG_WAIT) && !id_full;

  assign crc_din  = cur_byte;
  assign crc_seed = load && ((((seg_q == SG_HPRE) || (seg_q == SG_DPRE)) && (cnt_q == '0)) ||
                             (((seg_q == SG_HMARK) || (seg_q == SG_DMARK)) && !mfm_q));
  assign crc_step = load && ((seg_q == SG_HPRE) || (seg_q == SG_DPRE) || (seg_q == SG_HMARK) ||
                             (seg_q == SG_DMARK) || (seg_q == SG_HFLD) || (seg_q == SG_FILL));

  assign sym_valid = sv_q;
  assign sym_data  = sd_q;
  assign sym_mark  = sm_q;
  assign done      = (seg_q == SG_DONE) && !sv_q;
  assign timeout   = (seg_q == SG_TMO);
endmodule

// File: rtl/fmt_track_gen.sv
module fmt_track_gen #(
  parameter int REC_W      = 14,
  parameter int GAP_W      = 8,
  parameter int SEC_W      = 8,
  parameter int TMO_CYCLES = 20000
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             cfg_mfm,
  input  logic [7:0]       cfg_filler,
  input  logic [GAP_W-1:0] cfg_gap3,
  input  logic [REC_W-1:0] cfg_reclen,
  input  logic [SEC_W-1:0] cfg_sectors,
  output logic             host_req,
  input  logic             host_valid,
  input  logic [7:0]       host_data,
  output logic             sym_valid,
  output logic [7:0]       sym_data,
  output logic             sym_mark,
  input  logic             sym_take,
  output logic             done,
  output logic             timeout
);
  logic        flush, arm, id_full, id_empty, expired;
  logic [31:0] id_flat;
  logic        crc_seed, crc_step;
  logic [7:0]  crc_din;
  logic [15:0] crc;

  fmt_id_port #(.TMO_CYCLES(TMO_CYCLES)) u_ids (
    .clk(clk), .rst(rst), .host_req(host_req), .host_valid(host_valid),
    .host_data(host_data), .flush(flush), .arm(arm), .id_full(id_full),
    .id_empty(id_empty), .id_flat(id_flat), .expired(expired)
  );

  fmt_crc u_crc (
    .clk(clk), .rst(rst), .seed(crc_seed), .step(crc_step), .din(crc_din), .crc(crc)
  );

  fmt_seq #(.REC_W(REC_W), .GAP_W(GAP_W), .SEC_W(SEC_W)) u_seq (
    .clk(clk), .rst(rst), .start(start), .cfg_mfm(cfg_mfm), .cfg_filler(cfg_filler),
    .cfg_gap3(cfg_gap3), .cfg_reclen(cfg_reclen), .cfg_sectors(cfg_sectors),
    .id_full(id_full), .id_empty(id_empty), .id_flat(id_flat), .expired(expired),
    .crc(crc), .sym_take(sym_take), .flush(flush), .arm(arm), .host_req(host_req),
    .crc_seed(crc_seed), .crc_step(crc_step), .crc_din(crc_din),
    .sym_valid(sym_valid), .sym_data(sym_data), .sym_mark(sym_mark),
    .done(done), .timeout(timeout)
  );
endmodule

// File: rtl/fmt_track_gen_chk.sv
module fmt_track_gen_chk (
  input logic       clk,
  input logic       rst,
  input logic       sym_valid,
  input logic [7:0] sym_data,
  input logic       sym_mark,
  input logic       sym_take,
  input logic       host_req,
  input logic       done,
  input logic       timeout
);
  AST_RESET_QUIET: assert property (@(posedge clk)
    $past(rst) |-> (!sym_valid && !host_req && !done && !timeout)); // R12

  AST_SYMBOL_HOLD: assert property (@(posedge clk) disable iff (rst)
    (sym_valid && !sym_take) |=> (sym_valid && $stable(sym_data) && $stable(sym_mark))); // R13

  AST_MARK_CODE: assert property (@(posedge clk) disable iff (rst)
    (sym_valid && sym_mark) |-> (sym_data == 8'hC2 || sym_data == 8'hA1 ||
                                 sym_data == 8'hFC || sym_data == 8'hFE || sym_data == 8'hFB)); // R3

  AST_REQ_ACTIVE: assert property (@(posedge clk) disable iff (rst)
    host_req |-> (!done && !timeout)); // R5

  AST_END_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(done && timeout)); // R11

  AST_DONE_DRAINED: assert property (@(posedge clk) disable iff (rst)
    done |-> !sym_valid); // R10
endmodule

bind fmt_track_gen fmt_track_gen_chk i_chk (
  .clk(clk), .rst(rst), .sym_valid(sym_valid), .sym_data(sym_data),
  .sym_mark(sym_mark), .sym_take(sym_take), .host_req(host_req),
  .done(done), .timeout(timeout)
);

// File: tb/test_fmt_track_gen.sv
module test_fmt_track_gen;
  localparam int CLK_PERIOD = 10;
  localparam int TMO = 300;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0, cfg_mfm = 1'b0, host_valid = 1'b0, sym_take = 1'b0;
  logic [7:0] cfg_filler = '0, host_data = '0;
  logic [7:0] cfg_gap3 = '0;
  logic [13:0] cfg_reclen = '0;
  logic [7:0] cfg_sectors = '0;
  logic host_req, sym_valid, sym_mark, done, timeout;
  logic [7:0] sym_data;

  int checks = 0, errors = 0;
  logic [8:0] exp_q[$];
  string      tag_q[$];
  int         need_q[$];
  logic [7:0] ids[64];

  always #(CLK_PERIOD/2) clk = ~clk;

  fmt_track_gen #(.REC_W(14), .GAP_W(8), .SEC_W(8), .TMO_CYCLES(TMO)) i_fmt_track_gen (
    .clk(clk), .rst(rst), .start(start), .cfg_mfm(cfg_mfm), .cfg_filler(cfg_filler),
    .cfg_gap3(cfg_gap3), .cfg_reclen(cfg_reclen), .cfg_sectors(cfg_sectors),
    .host_req(host_req), .host_valid(host_valid), .host_data(host_data),
    .sym_valid(sym_valid), .sym_data(sym_data), .sym_mark(sym_mark),
    .sym_take(sym_take), .done(done), .timeout(timeout)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] ref_crc(input logic [15:0] c, input logic [7:0] d);
    logic [15:0] r = c ^ {d, 8'h00};
    for (int k = 0; k < 8; k++) r = r[15] ? ((r << 1) ^ 16'h1021) : (r << 1);
    return r;
  endfunction

  task automatic put(input int n, input logic [7:0] b, input logic m, input string t, input int need);
    for (int k = 0; k < n; k++) begin
      exp_q.push_back({m, b});
      tag_q.push_back(t);
      need_q.push_back(need);
    end
  endtask

  task automatic build(input bit mfm, input logic [7:0] fill, input int gap3, input int rec, input int nsec);
    logic [7:0]  g = mfm ? 8'h4E : 8'hFF;
    int          sync = mfm ? 12 : 6;
    logic [15:0] c;
    exp_q.delete(); tag_q.delete(); need_q.delete();
    put(mfm ? 80 : 40, g, 1'b0, "R1", 0);
    put(sync, 8'h00, 1'b0, "R2", 0);
    if (mfm) put(3, 8'hC2, 1'b1, "R3", 0);
    put(1, 8'hFC, !mfm, "R3", 0);
    put(mfm ? 50 : 26, g, 1'b0, "R4", 0);
    for (int s = 0; s < nsec; s++) begin
      put(sync, 8'h00, 1'b0, "R6", 4 * (s + 1));
      c = 16'hFFFF;
      if (mfm) for (int k = 0; k < 3; k++) begin put(1, 8'hA1, 1'b1, "R6", 0); c = ref_crc(c, 8'hA1); end
      put(1, 8'hFE, !mfm, "R6", 0); c = ref_crc(c, 8'hFE);
      for (int k = 0; k < 4; k++) begin put(1, ids[4*s+k], 1'b0, "R6", 0); c = ref_crc(c, ids[4*s+k]); end
      put(1, c[15:8], 1'b0, "R7", 0); put(1, c[7:0], 1'b0, "R7", 0);
      put(mfm ? 22 : 11, g, 1'b0, "R8", 0);
      put(sync, 8'h00, 1'b0, "R8", 0);
      c = 16'hFFFF;
      if (mfm) for (int k = 0; k < 3; k++) begin put(1, 8'hA1, 1'b1, "R8", 0); c = ref_crc(c, 8'hA1); end
      put(1, 8'hFB, !mfm, "R8", 0); c = ref_crc(c, 8'hFB);
      for (int k = 0; k < rec; k++) begin put(1, fill, 1'b0, "R9", 0); c = ref_crc(c, fill); end
      put(1, c[15:8], 1'b0, "R7", 0); put(1, c[7:0], 1'b0, "R7", 0);
      put(gap3, g, 1'b0, "R9", 0);
    end
  endtask

  task automatic kick(input bit mfm, input logic [7:0] fill, input int gap3, input int rec, input int nsec);
    @(negedge clk);
    cfg_mfm = mfm; cfg_filler = fill; cfg_gap3 = 8'(gap3);
    cfg_reclen = 14'(rec); cfg_sectors = 8'(nsec);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic run_track(input bit mfm, input logic [7:0] fill, input int gap3,
                           input int rec, input int nsec, input int take_pct);
    int given = 0, cyc = 0, req_cycles = 0, got = 0;
    logic [8:0] e; string t; int nd;
    for (int k = 0; k < 4 * nsec; k++) ids[k] = 8'($urandom);
    build(mfm, fill, gap3, rec, nsec);
    kick(mfm, fill, gap3, rec, nsec);
    while (!done && cyc < 40000) begin
      @(negedge clk);
      cyc++;
      host_valid = 1'b0;
      if (host_req) req_cycles++;
      if (host_req && given < 4 * nsec && ($urandom % 100) < 60) begin
        host_valid = 1'b1; host_data = ids[given]; given++;
      end
      sym_take = (($urandom % 100) < take_pct);
      if (sym_valid && sym_take) begin
        got++;
        if (exp_q.size() == 0) chk("R10 extra symbol", 32'(got), 32'(0));
        else begin
          e = exp_q.pop_front(); t = tag_q.pop_front(); nd = need_q.pop_front();
          chk(t, {23'b0, sym_mark, sym_data}, {23'b0, e});
          if (nd > 0) chk("R5 ID bytes before field", 32'(given >= nd), 32'(1));
        end
      end
    end
    sym_take = 1'b0; host_valid = 1'b0;
    @(negedge clk);
    chk("R10 stream fully emitted", 32'(exp_q.size()), 32'(0));
    chk("R10 done after last sector", 32'(done), 32'(1));
    chk("R5 host bytes consumed", 32'(given), 32'(4 * nsec));
    chk("R11 no timeout on normal run", 32'(timeout), 32'(0));
    if (nsec == 0) chk("R5 no request with zero sectors", 32'(req_cycles), 32'(0));
  endtask

  task automatic run_timeout();
    int cyc = 0;
    kick(1'b0, 8'hE5, 10, 16, 2);
    sym_take = 1'b1;
    while (!host_req && cyc < 2000) begin @(negedge clk); cyc++; end
    chk("R5 request raised after index part", 32'(host_req), 32'(1));
    for (int n = 1; n <= TMO + 1; n++) begin
      @(negedge clk);
      if (n == TMO) chk("R11 timeout not yet", 32'(timeout), 32'(0));
      if (n == TMO + 1) begin
        chk("R11 timeout asserted", 32'(timeout), 32'(1));
        chk("R11 request dropped", 32'(host_req), 32'(0));
        chk("R11 done stays low", 32'(done), 32'(0));
      end
    end
    sym_take = 1'b0;
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R12 sym_valid after reset", 32'(sym_valid), 32'(0));
    chk("R12 host_req after reset", 32'(host_req), 32'(0));
    chk("R12 done after reset", 32'(done), 32'(0));
    chk("R12 timeout after reset", 32'(timeout), 32'(0));
    rst = 1'b0;
    run_track(1'b0, 8'hE5, 27, 32, 2, 70);
    run_track(1'b1, 8'hE5, 20, 64, 3, 50);
    run_track(1'b1, 8'h00, 1, 1, 1, 100);   // R13 full rate, R9 minimum sizes
    run_track(1'b0, 8'hF6, 5, 8, 0, 80);
    run_timeout();
    run_track(1'b1, 8'h5A, 12, 10, 1, 90);
    for (int r = 0; r < 5; r++)
      run_track(1'($urandom), 8'($urandom), 1 + int'($urandom % 40), 1 + int'($urandom % 100),
                1 + int'($urandom % 4), 30 + int'($urandom % 71));
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL R10 watchdog: got no completion expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule